// File: doc/BRIEF.md
# Reconfigurable Systolic Array Cell

This block is one processing element meant to be tiled into an evolvable systolic array that streams data such as image pixels. It takes three 8-bit data inputs and drives three 8-bit data outputs. Inside sits one functional unit whose operation can be swapped at run time by writing a 10-bit configuration word. The same word also decides, separately for every output, whether that output carries the function result or passes one of the three inputs straight through. Each output therefore acts either as a compute path or as a routing wire. A search algorithm that evolves the array needs nothing more than one word per cell.

All three outputs are registered, so a chain of cells forms a pipeline that accepts one new data set per clock. A valid flag moves through the same register stage as the data, which keeps neighbouring cells aligned. A new configuration word is captured on a load strobe. It applies to data from the following cycle onward, so an output never mixes two configurations.

Top module: `hexcell_top`

## Requirements
- R1: While `rst_n` is low, all three data outputs are 0 and `out_valid` is 0. After reset, the configuration is function code 0 with every output select 0, so each output shows input 0.
- R2: The configuration word is laid out as bits [9:6] function code, [5:4] select of output 0, [3:2] select of output 1, and [1:0] select of output 2. A word presented with `cfg_load` high is captured at that clock edge. Data captured at that same edge still uses the previous word. Data from the next cycle onward uses the new word.
- R3: While `cfg_load` is low, changes on `cfg_word` have no effect on any output.
- R4: Each output select is independent of the others. Select 0 gives the function result, select 1 gives input 0, select 2 gives input 1, and select 3 gives input 2.
- R5: Function code 0 passes input 0. Codes 1, 2 and 3 give the bitwise AND, OR and XOR of inputs 0 and 1.
- R6: Function code 4 adds inputs 0 and 1 and saturates the sum at 255.
- R7: Function code 5 gives the absolute difference of inputs 0 and 1.
- R8: Function code 6 gives the maximum of inputs 0 and 1. Function code 7 gives their minimum.
- R9: Function code 8 gives floor((in0 + in1 + in2) / 3), with no overflow for any input values.
- R10: Function codes 9 to 15 give a result of 0.
- R11: `out_valid` equals `in_valid` delayed by exactly one clock. When `in_valid` is high, the data outputs show the result for that cycle's inputs one clock later.
- R12: When `in_valid` is low, the data outputs keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Capture `cfg_word` at this edge |
| cfg_word | input | 10 | Function code and three output selects |
| in_valid | input | 1 | Input data valid |
| in_d0 | input | 8 | Data input 0 |
| in_d1 | input | 8 | Data input 1 |
| in_d2 | input | 8 | Data input 2 |
| out_valid | output | 1 | Output data valid, one cycle after `in_valid` |
| out_d0 | output | 8 | Registered data output 0 |
| out_d1 | output | 8 | Registered data output 1 |
| out_d2 | output | 8 | Registered data output 2 |

## Verification
Directed operand pairs exercise both orderings of the two inputs. This separates the absolute difference, maximum and minimum from a plain subtraction or a fixed pick. Sums above 255 tell saturation apart from wrap-around, and three inputs of 255 expose any truncated average. A select pattern of 1,2,3 followed by a permuted mix shows whether the outputs are truly independent and the select encoding is in the right order. Loads placed next to valid data fix the cycle in which a new word applies. A long run of random words, data and valid gaps then compares every output against a bench model.

// File: rtl/hexcell_pkg.sv
package hexcell_pkg;
  localparam int FN_W    = 4;
  localparam int SEL_W   = 2;
  localparam int N_PORT  = 3;
  localparam int CFG_W   = FN_W + N_PORT * SEL_W;

  localparam logic [FN_W-1:0] FN_PASS    = 4'd0;
  localparam logic [FN_W-1:0] FN_AND     = 4'd1;
  localparam logic [FN_W-1:0] FN_OR      = 4'd2;
  localparam logic [FN_W-1:0] FN_XOR     = 4'd3;
  localparam logic [FN_W-1:0] FN_SATADD  = 4'd4;
  localparam logic [FN_W-1:0] FN_ABSDIFF = 4'd5;
  localparam logic [FN_W-1:0] FN_MAX     = 4'd6;
  localparam logic [FN_W-1:0] FN_MIN     = 4'd7;
  localparam logic [FN_W-1:0] FN_AVG3    = 4'd8;

  localparam logic [SEL_W-1:0] SEL_FU  = 2'd0;
  localparam logic [SEL_W-1:0] SEL_IN0 = 2'd1;
  localparam logic [SEL_W-1:0] SEL_IN1 = 2'd2;
  localparam logic [SEL_W-1:0] SEL_IN2 = 2'd3;

  typedef struct packed {
    logic [FN_W-1:0]                 fn;
    logic [0:N_PORT-1][SEL_W-1:0]    sel;
  } cell_cfg_t;
endpackage

// File: rtl/hexcell_cfg.sv
module hexcell_cfg
  import hexcell_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CFG_W-1:0] word,
  output cell_cfg_t        cfg_q
);
  cell_cfg_t cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (load) cfg_d = cell_cfg_t'(word);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  a_r3_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(cfg_q));

  a_r2_cfg_capture: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cfg_q == cell_cfg_t'($past(word))));
endmodule

// File: rtl/hexcell_fu.sv
module hexcell_fu
  import hexcell_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [FN_W-1:0] fn,
  input  logic [DW-1:0]   a,
  input  logic [DW-1:0]   b,
  input  logic [DW-1:0]   c,
  output logic [DW-1:0]   res
);
  localparam int SUM2_W = DW + 1;
  localparam int SUM3_W = DW + 2;

  logic [SUM2_W-1:0] sum2;
  logic [SUM3_W-1:0] sum3;
  logic [SUM3_W-1:0] quot3;
  logic [DW-1:0]     hi;
  logic [DW-1:0]     lo;

  always_comb begin
    sum2  = {1'b0, a} + {1'b0, b};
    sum3  = {2'b00, a} + {2'b00, b} + {2'b00, c};
    quot3 = sum3 / SUM3_W'(3);
    hi    = (a >= b) ? a : b;
    lo    = (a >= b) ? b : a;
    case (fn)
      FN_PASS:    res = a;
      FN_AND:     res = a & b;
      FN_OR:      res = a | b;
      FN_XOR:     res = a ^ b;
      FN_SATADD:  res = sum2[DW] ? '1 : sum2[DW-1:0];
      FN_ABSDIFF: res = hi - lo;
      FN_MAX:     res = hi;
      FN_MIN:     res = lo;
      FN_AVG3:    res = quot3[DW-1:0];
      default:    res = '0;
    endcase
  end

  a_r6_sat_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (fn == FN_SATADD) |-> (res >= a && res >= b));

  a_r8_max_is_operand: assert property (@(posedge clk) disable iff (!rst_n)
    (fn == FN_MAX) |-> (res >= a && res >= b && (res == a || res == b)));

  a_r8_min_is_operand: assert property (@(posedge clk) disable iff (!rst_n)
    (fn == FN_MIN) |-> (res <= a && res <= b && (res == a || res == b)));

  a_r10_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (fn > FN_AVG3) |-> (res == '0));
endmodule

// File: rtl/hexcell_route.sv
module hexcell_route
  import hexcell_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0]                 fu_res,
  input  logic [N_PORT-1:0][DW-1:0]     in_bus,
  input  logic [0:N_PORT-1][SEL_W-1:0]  sel,
  output logic [N_PORT-1:0][DW-1:0]     out_bus
);
  for (genvar p = 0; p < N_PORT; p++) begin : g_port
    always_comb begin
      case (sel[p])
        SEL_IN0: out_bus[p] = in_bus[0];
        SEL_IN1: out_bus[p] = in_bus[1];
        SEL_IN2: out_bus[p] = in_bus[2];
        default: out_bus[p] = fu_res;
      endcase
    end
  end
endmodule

// File: rtl/hexcell_top.sv
module hexcell_top
  import hexcell_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_load,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic             in_valid,
  input  logic [DW-1:0]    in_d0,
  input  logic [DW-1:0]    in_d1,
  input  logic [DW-1:0]    in_d2,
  output logic             out_valid,
  output logic [DW-1:0]    out_d0,
  output logic [DW-1:0]    out_d1,
  output logic [DW-1:0]    out_d2
);
  cell_cfg_t                  cfg_q;
  logic [DW-1:0]              fu_res;
  logic [N_PORT-1:0][DW-1:0]  in_bus;
  logic [N_PORT-1:0][DW-1:0]  routed;
  logic [N_PORT-1:0][DW-1:0]  dat_d;
  logic [N_PORT-1:0][DW-1:0]  dat_q;
  logic                       vld_q;

  assign in_bus[0] = in_d0;
  assign in_bus[1] = in_d1;
  assign in_bus[2] = in_d2;

  hexcell_cfg u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (cfg_load),
    .word  (cfg_word),
    .cfg_q (cfg_q)
  );

  hexcell_fu #(.DW(DW)) u_fu (
    .clk   (clk),
    .rst_n (rst_n),
    .fn    (cfg_q.fn),
    .a     (in_d0),
    .b     (in_d1),
    .c     (in_d2),
    .res   (fu_res)
  );

  hexcell_route #(.DW(DW)) u_route (
    .fu_res  (fu_res),
    .in_bus  (in_bus),
    .sel     (cfg_q.sel),
    .out_bus (routed)
  );

  always_comb begin
    dat_d = dat_q;
    if (in_valid) dat_d = routed;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_q <= '0;
      vld_q <= 1'b0;
    end else begin
      dat_q <= dat_d;
      vld_q <= in_valid;
    end
  end

  assign out_valid = vld_q;
  assign out_d0    = dat_q[0];
  assign out_d1    = dat_q[1];
  assign out_d2    = dat_q[2];

  a_r11_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r11_invalid_latency: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r12_hold_on_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_d0) && $stable(out_d1) && $stable(out_d2)));

  a_r4_bypass_port0: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !cfg_load && cfg_q.sel[0] == SEL_IN2) |=> (out_d0 == $past(in_d2)));

  a_r4_bypass_port2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !cfg_load && cfg_q.sel[2] == SEL_IN0) |=> (out_d2 == $past(in_d0)));
endmodule

// File: tb/hexcell_top_bench.sv
`timescale 1ns/1ps
module hexcell_top_bench;
  logic       clk;
  logic       rst_n;
  logic       cfg_load;
  logic [9:0] cfg_word;
  logic       in_valid;
  logic [7:0] in_d0, in_d1, in_d2;
  logic       out_valid;
  logic [7:0] out_d0, out_d1, out_d2;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [9:0] cur_cfg;
  logic [7:0] e0, e1, e2;
  logic       ev;

  hexcell_top u_hexcell_top (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_word(cfg_word),
    .in_valid(in_valid), .in_d0(in_d0), .in_d1(in_d1), .in_d2(in_d2),
    .out_valid(out_valid), .out_d0(out_d0), .out_d1(out_d1), .out_d2(out_d2)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [9:0] mk(input int fn, input int s0, input int s1, input int s2);
    return {4'(fn), 2'(s0), 2'(s1), 2'(s2)};
  endfunction

  function automatic logic [7:0] fmodel(input logic [3:0] fn, input logic [7:0] a,
                                        input logic [7:0] b, input logic [7:0] c);
    int ai, bi, ci, r;
    ai = a; bi = b; ci = c;
    case (fn)
      4'd0: r = ai;
      4'd1: r = ai & bi;
      4'd2: r = ai | bi;
      4'd3: r = ai ^ bi;
      4'd4: r = (ai + bi > 255) ? 255 : ai + bi;
      4'd5: r = (ai > bi) ? ai - bi : bi - ai;
      4'd6: r = (ai > bi) ? ai : bi;
      4'd7: r = (ai < bi) ? ai : bi;
      4'd8: r = (ai + bi + ci) / 3;
      default: r = 0;
    endcase
    return 8'(r);
  endfunction

  function automatic logic [7:0] rmodel(input logic [1:0] s, input logic [7:0] f,
                                        input logic [7:0] a, input logic [7:0] b,
                                        input logic [7:0] c);
    case (s)
      2'd0: return f;
      2'd1: return a;
      2'd2: return b;
      default: return c;
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // called at a negedge; checks outputs at the following negedge
  task automatic step(input logic ld, input logic [9:0] w, input logic v,
                      input logic [7:0] a, input logic [7:0] b, input logic [7:0] c,
                      input string tag);
    logic [7:0] f;
    cfg_load = ld; cfg_word = w; in_valid = v;
    in_d0 = a; in_d1 = b; in_d2 = c;
    @(posedge clk);
    if (v) begin
      f  = fmodel(cur_cfg[9:6], a, b, c);
      e0 = rmodel(cur_cfg[5:4], f, a, b, c);
      e1 = rmodel(cur_cfg[3:2], f, a, b, c);
      e2 = rmodel(cur_cfg[1:0], f, a, b, c);
    end
    ev = v;
    if (ld) cur_cfg = w;
    @(negedge clk);
    chk({tag, " out0"}, out_d0, e0);
    chk({tag, " out1"}, out_d1, e1);
    chk({tag, " out2"}, out_d2, e2);
    chk("R11 valid", out_valid, ev);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; cfg_load = 1'b0; cfg_word = '0; in_valid = 1'b0;
    in_d0 = '0; in_d1 = '0; in_d2 = '0;
    cur_cfg = '0; e0 = '0; e1 = '0; e2 = '0; ev = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1 out0", out_d0, 0);
    chk("R1 out1", out_d1, 0);
    chk("R1 out2", out_d2, 0);
    chk("R1 valid", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: default configuration passes input 0 to every output
    step(0, '0, 1, 8'd77, 8'd5, 8'd9, "R1");

    // R2: load timing, same-edge data uses the old word
    step(1, mk(3, 0, 0, 0), 1, 8'hF0, 8'h3C, 8'h01, "R2");
    step(0, '0, 1, 8'hF0, 8'h3C, 8'h01, "R2");
    // R3: cfg_word changes without load are ignored
    step(0, mk(2, 1, 1, 1), 1, 8'hAA, 8'h0F, 8'h00, "R3");
    step(0, mk(9, 3, 3, 3), 1, 8'h12, 8'h34, 8'h56, "R3");

    // R4: independent selects
    step(1, mk(1, 1, 2, 3), 0, 0, 0, 0, "R4");
    step(0, '0, 1, 8'd11, 8'd22, 8'd33, "R4");
    step(1, mk(7, 3, 0, 2), 0, 0, 0, 0, "R4");
    step(0, '0, 1, 8'd90, 8'd40, 8'd7, "R4");
    step(1, mk(6, 2, 1, 0), 0, 0, 0, 0, "R4");
    step(0, '0, 1, 8'd3, 8'd200, 8'd100, "R4");

    // R5: logic codes
    for (int k = 0; k < 4; k++) begin
      step(1, mk(k, 0, 0, 0), 0, 0, 0, 0, "R5");
      step(0, '0, 1, 8'b1100_1010, 8'b1010_0110, 8'd1, "R5");
    end

    // R6: saturating add
    step(1, mk(4, 0, 0, 0), 0, 0, 0, 0, "R6");
    step(0, '0, 1, 8'd200, 8'd100, 8'd0, "R6");
    step(0, '0, 1, 8'd10, 8'd20, 8'd0, "R6");
    step(0, '0, 1, 8'd255, 8'd0, 8'd0, "R6");
    step(0, '0, 1, 8'd128, 8'd128, 8'd0, "R6");

    // R7: absolute difference, both orders
    step(1, mk(5, 0, 0, 0), 0, 0, 0, 0, "R7");
    step(0, '0, 1, 8'd3, 8'd10, 8'd0, "R7");
    step(0, '0, 1, 8'd10, 8'd3, 8'd0, "R7");

    // R8: max and min, both orders
    step(1, mk(6, 0, 0, 0), 0, 0, 0, 0, "R8");
    step(0, '0, 1, 8'd5, 8'd250, 8'd0, "R8");
    step(0, '0, 1, 8'd250, 8'd5, 8'd0, "R8");
    step(1, mk(7, 0, 0, 0), 0, 0, 0, 0, "R8");
    step(0, '0, 1, 8'd5, 8'd250, 8'd0, "R8");
    step(0, '0, 1, 8'd250, 8'd5, 8'd0, "R8");

    // R9: three-input average
    step(1, mk(8, 0, 0, 0), 0, 0, 0, 0, "R9");
    step(0, '0, 1, 8'd255, 8'd255, 8'd255, "R9");
    step(0, '0, 1, 8'd1, 8'd1, 8'd0, "R9");
    step(0, '0, 1, 8'd2, 8'd2, 8'd2, "R9");
    step(0, '0, 1, 8'd0, 8'd100, 8'd201, "R9");

    // R10: unused codes give zero
    for (int k = 9; k < 16; k++) begin
      step(1, mk(k, 0, 0, 0), 0, 0, 0, 0, "R10");
      step(0, '0, 1, 8'hFF, 8'hFF, 8'hFF, "R10");
    end

    // R12: invalid data leaves outputs unchanged
    step(1, mk(4, 0, 1, 3), 0, 0, 0, 0, "R12");
    step(0, '0, 1, 8'd40, 8'd50, 8'd60, "R12");
    step(0, '0, 0, 8'd1, 8'd2, 8'd3, "R12");
    step(0, '0, 0, 8'd9, 8'd8, 8'd7, "R12");
    // R11: valid returns after a gap
    step(0, '0, 1, 8'd1, 8'd2, 8'd3, "R11");

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic ld, v;
      ld = ($urandom % 6) == 0;
      v  = ($urandom % 4) != 0;
      step(ld, 10'($urandom), v, 8'($urandom), 8'($urandom), 8'($urandom), "R11 random");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule